// File: doc/BRIEF.md
# Select-Qualified Bus Stability Checker

This block watches a wide data bus next to a multiplexer select line. In each clock cycle where the select is high, it compares every bus bit with the value that bit had one cycle earlier. The bus must hold steady across the two consecutive clocks that lead into the selection. Any bit that moved counts as a violation.

Some bits may legally float or carry meaningless values in the current mode. A per-bit ignore mask removes those bits from the comparison. A bit is left out when its mask bit is set in either of the two cycles being compared. One history stage keeps the previous bus value and mask. Because that stage holds nothing useful straight after reset, the first cycle after reset is never checked.

A violation produces three results in the cycle after the failing select cycle:
- a one-cycle error pulse;
- a vector that names the offending bits;
- a sticky flag that stays set until the next reset.

Top module: `sel_stable_chk`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any clock edge where `rst` is 1, `err_pulse`, `err_sticky` and `err_bits` are all 0.
- R2: When `sel` is 1 in cycle k and an unmasked bit of `data` in cycle k differs from cycle k-1, `err_pulse` is 1 in cycle k+1. Otherwise `err_pulse` is 0 in cycle k+1.
- R3: In cycle k+1, `err_bits[i]` is 1 exactly for those bits i that failed the cycle-k check. `err_bits` is all zero whenever `err_pulse` is 0.
- R4: A bit whose `ignore_mask` bit is 1 in the select cycle k is never reported, even if it changed.
- R5: A bit whose `ignore_mask` bit was 1 in the previous cycle k-1 is never reported, even if it changed.
- R6: No check is made in the first cycle after reset deasserts. A select there gives no error, whatever the data did.
- R7: `err_sticky` goes to 1 together with the first `err_pulse`. It stays 1 until a reset edge, even after the pulse ends.
- R8: In cycles where `sel` is 0, bus changes produce no error.
- R9: Select held high over consecutive cycles checks each cycle on its own against its predecessor. Each failing cycle gives its own pulse, so pulses can be back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Mux select; when 1, the current cycle is checked |
| data | input | W | Watched data bus |
| ignore_mask | input | W | Per-bit don't-care flags for the current cycle |
| err_pulse | output | 1 | One-cycle violation pulse |
| err_sticky | output | 1 | Violation seen since last reset |
| err_bits | output | W | Bits that failed the last checked cycle |

## Verification
Two functions can act in the same cycle: mismatch detection and mask exclusion. This is provoked by changing several bits at once under select, with some of them masked in the current cycle, some masked in the previous cycle, and one left unmasked. It is judged by requiring `err_bits` to name only the unmasked bit while the pulse still fires. A second overlap places a failing select directly after another failing select. Each pulse must report only its own cycle's bits, and the sticky flag stays set between them.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Validity of the one-deep history stage.
    typedef enum logic {
        HIST_EMPTY  = 1'b0,
        HIST_PRIMED = 1'b1
    } hist_state_e;

    // Single-bit report flags carried between compare and report stage.
    typedef struct packed {
        logic pulse;
        logic sticky;
    } err_flags_t;

    // A bit is judged only when neither cycle marks it as don't-care.
    function automatic logic bit_judged(input logic mask_now, input logic mask_then);
        return !(mask_now || mask_then);
    endfunction

    // Bit failure: judged, enabled and changed.
    function automatic logic bit_failed(input logic en, input logic judged,
                                        input logic now_v, input logic then_v);
        return en && judged && (now_v != then_v);
    endfunction

endpackage

// File: rtl/ssc_history.sv
module ssc_history
    import ssc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] prev_data,
    output logic [W-1:0] prev_mask,
    output logic         primed
);

    hist_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= HIST_EMPTY;
            prev_data <= '0;
            prev_mask <= '1;
        end else begin
            state_q   <= HIST_PRIMED;
            prev_data <= data;
            prev_mask <= mask;
        end
    end

    assign primed = (state_q == HIST_PRIMED);

endmodule

// File: rtl/ssc_compare.sv
module ssc_compare
    import ssc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         enable,
    input  logic [W-1:0] cur_data,
    input  logic [W-1:0] cur_mask,
    input  logic [W-1:0] prev_data,
    input  logic [W-1:0] prev_mask,
    output logic [W-1:0] fail_vec
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic judged;
        always_comb begin
            judged      = bit_judged(cur_mask[i], prev_mask[i]);
            fail_vec[i] = bit_failed(enable, judged, cur_data[i], prev_data[i]);
        end
    end

endmodule

// File: rtl/ssc_report.sv
module ssc_report
    import ssc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fail_vec,
    output logic         err_pulse,
    output logic         err_sticky,
    output logic [W-1:0] err_bits
);

    err_flags_t flags_q;
    err_flags_t flags_d;
    logic [W-1:0] bits_q;

    always_comb begin
        flags_d.pulse  = |fail_vec;
        flags_d.sticky = flags_q.sticky | flags_d.pulse;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            bits_q  <= '0;
        end else begin
            flags_q <= flags_d;
            bits_q  <= fail_vec;
        end
    end

    assign err_pulse  = flags_q.pulse;
    assign err_sticky = flags_q.sticky;
    assign err_bits   = bits_q;

endmodule

// File: rtl/sel_stable_chk.sv
module sel_stable_chk
    import ssc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic [W-1:0] data,
    input  logic [W-1:0] ignore_mask,
    output logic         err_pulse,
    output logic         err_sticky,
    output logic [W-1:0] err_bits
);

    logic [W-1:0] hist_data;
    logic [W-1:0] hist_mask;
    logic         hist_primed;
    logic [W-1:0] fail_vec;
    logic         chk_en;

    ssc_history #(.W(W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .data      (data),
        .mask      (ignore_mask),
        .prev_data (hist_data),
        .prev_mask (hist_mask),
        .primed    (hist_primed)
    );

    assign chk_en = sel && hist_primed;

    ssc_compare #(.W(W)) u_cmp (
        .enable    (chk_en),
        .cur_data  (data),
        .cur_mask  (ignore_mask),
        .prev_data (hist_data),
        .prev_mask (hist_mask),
        .fail_vec  (fail_vec)
    );

    ssc_report #(.W(W)) u_rep (
        .clk        (clk),
        .rst        (rst),
        .fail_vec   (fail_vec),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky),
        .err_bits   (err_bits)
    );

endmodule

// File: rtl/ssc_props.sv
module ssc_props #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         sel,
    input logic [W-1:0] ignore_mask,
    input logic         err_pulse,
    input logic         err_sticky,
    input logic [W-1:0] err_bits
);

    // R1: outputs clear after a reset edge
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!err_pulse && !err_sticky && err_bits == '0));

    // R2: a pulse always follows a select cycle
    p_pulse_needs_sel_r2: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(sel));

    // R3: bit vector nonzero exactly with the pulse
    p_bits_with_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        err_pulse == (err_bits != '0));

    // R4: bits masked in the select cycle never reported
    p_mask_now_r4: assert property (@(posedge clk) disable iff (rst)
        (err_bits & $past(ignore_mask)) == '0);

    // R5: bits masked in the cycle before select never reported
    p_mask_then_r5: assert property (@(posedge clk) disable iff (rst)
        (err_bits & $past(ignore_mask, 2)) == '0);

    // R6: no report from the first cycle after reset
    p_no_first_check_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst, 2) |-> !err_pulse);

    // R7: sticky accompanies pulse and holds
    p_sticky_follows_r7: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);

    p_sticky_holds_r7: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

endmodule

bind sel_stable_chk ssc_props #(.W(W)) u_props (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .ignore_mask (ignore_mask),
    .err_pulse   (err_pulse),
    .err_sticky  (err_sticky),
    .err_bits    (err_bits)
);

// File: tb/test_sel_stable_chk.sv
`timescale 1ns/1ps
module test_sel_stable_chk;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel = 1'b0;
    logic [W-1:0] data = '0;
    logic [W-1:0] ignore_mask = '0;
    logic         err_pulse;
    logic         err_sticky;
    logic [W-1:0] err_bits;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    logic [W-1:0] m_last_d = '0;
    logic [W-1:0] m_last_m = '1;
    bit           m_have_last = 0;
    logic         e_pulse = 0;
    logic         e_sticky = 0;
    logic [W-1:0] e_bits = '0;

    always #2.5 clk = ~clk;

    sel_stable_chk #(.W(W)) i_sel_stable_chk (
        .clk         (clk),
        .rst         (rst),
        .sel         (sel),
        .data        (data),
        .ignore_mask (ignore_mask),
        .err_pulse   (err_pulse),
        .err_sticky  (err_sticky),
        .err_bits    (err_bits)
    );

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit r, input bit s, input logic [W-1:0] d,
                       input logic [W-1:0] m, input string tag);
        rst = r; sel = s; data = d; ignore_mask = m;
        @(posedge clk);
        if (r) begin
            e_pulse = 0; e_sticky = 0; e_bits = '0; m_have_last = 0;
        end else begin
            logic [W-1:0] diff;
            diff = '0;
            if (s && m_have_last) begin
                for (int i = 0; i < W; i++)
                    if (!m[i] && !m_last_m[i] && d[i] != m_last_d[i]) diff[i] = 1'b1;
            end
            e_bits = diff;
            e_pulse = (diff != '0);
            if (e_pulse) e_sticky = 1;
            m_have_last = 1;
        end
        m_last_d = d;
        m_last_m = m;
        @(negedge clk);
        checks++;
        if (err_pulse !== e_pulse || err_sticky !== e_sticky || err_bits !== e_bits) begin
            failures++;
            $display("FAIL %s: actual pulse=%0b sticky=%0b bits=%h expected pulse=%0b sticky=%0b bits=%h",
                     tag, err_pulse, err_sticky, err_bits, e_pulse, e_sticky, e_bits);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] lfsr;
        logic [W-1:0] prev;
        @(negedge clk);
        // R1: reset state
        cyc(1, 0, 32'h0, 32'h0, "R1");
        cyc(1, 1, 32'hFFFF_FFFF, 32'h0, "R1");
        // R6: select right after reset, data changed from reset cycle
        cyc(0, 1, 32'h1234_5678, 32'h0, "R6");
        // R2: stable data under select, no error
        cyc(0, 1, 32'h1234_5678, 32'h0, "R2");
        cyc(0, 0, 32'h1234_5678, 32'h0, "R2");
        // R8: changes with select low
        cyc(0, 0, 32'hDEAD_BEEF, 32'h0, "R8");
        cyc(0, 0, 32'h0BAD_F00D, 32'h0, "R8");
        // R2/R3: single unmasked bit flips under select
        cyc(0, 1, 32'h0BAD_F00C, 32'h0, "R2");
        // R7: sticky stays, pulse ends
        cyc(0, 0, 32'h0BAD_F00C, 32'h0, "R7");
        cyc(0, 1, 32'h0BAD_F00C, 32'h0, "R7");
        // R4: masked in select cycle
        cyc(0, 1, 32'hF0AD_F00C, 32'hFF00_0000, "R4");
        // R5: masked in previous cycle only
        cyc(0, 0, 32'hF0AD_F00C, 32'h0000_00F0, "R5");
        cyc(0, 1, 32'hF0AD_F0FC, 32'h0000_0000, "R5");
        // R1: reset clears sticky
        cyc(1, 0, 32'h0, 32'h0, "R1");
        cyc(0, 0, 32'h0, 32'h0, "R1");
        cyc(0, 0, 32'h0, 32'h0, "R1");
        // R3/R4/R5 together: masked-now, masked-then, one unmasked
        cyc(0, 0, 32'h0000_0000, 32'h0000_000F, "R5");
        cyc(0, 1, 32'h0F00_00FF, 32'h0F00_0000, "R3");
        // R9: back-to-back failing selects
        cyc(0, 1, 32'h0F00_01FF, 32'h0, "R9");
        cyc(0, 1, 32'h0F00_03FF, 32'h0, "R9");
        cyc(0, 1, 32'h0F00_03FF, 32'h0, "R9");
        // R6 again after a second reset, with a stable sel afterwards
        cyc(1, 1, 32'hAAAA_AAAA, 32'h0, "R1");
        cyc(0, 1, 32'h5555_5555, 32'h0, "R6");
        cyc(0, 1, 32'h5555_5555, 32'h0, "R2");
        // R3: pseudo-random walk
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 300; n++) begin
            prev = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(0, lfsr[3], (lfsr[5:4] == 2'b00) ? prev : lfsr,
                lfsr[7] ? {lfsr[15:0], lfsr[31:16]} : 32'h0, "R3");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule